// File: doc/BRIEF.md
# Boot Handshake Mailbox with Status Waiter

This block is a word-addressed register file that a host controller and a remote processor's staged boot loader use to talk to each other. The host programs the boot image address, the metadata address, the code start address and the running code length, and it issues commands. The remote side has two write ports of its own. Through one it posts the first-stage loader result, and through the other it posts the second-stage loader result. The command register is decoded into one-cycle ready strobes. These strobes tell the remote side that metadata is ready or that the load is ready.

A built-in waiter spares the host from polling. When a wait starts, it latches the following: which status register to watch, an expected value, and a cycle limit. From then on it checks the chosen status once every cycle. If the expected value is zero, any nonzero status completes the wait. Otherwise only an exact match completes it. A status whose sign bit is set ends the wait at once as an error. If nothing completes the wait within the limit, a sticky timeout flag is raised.

The host fills the code length segment by segment. It first writes the register to zero. It then writes the code start and issues the load-ready command. After that, before each segment, it writes the previous length plus the segment size.

Top module: `boot_mbox`

## Requirements
- R1: After reset, every register reads zero, the waiter is idle, and all waiter flags and command strobes are low.
- R2: Host writes to the image address (0x00), metadata address (0x10), code start (0x14) and code length (0x18) are stored. A host read request of an offset returns that register on `host_rdata_o` after the next clock edge. Unmapped offsets read zero.
- R3: A host write of 1 to the command register (0x08) pulses `meta_ready_o` high for exactly one cycle. A write of 2 pulses `load_ready_o` for one cycle. Any other value pulses neither. The written command reads back.
- R4: Host writes to the first-stage status (0x04) and second-stage status (0x0C) offsets are ignored.
- R5: The remote ports update the first-stage and second-stage status registers. A host read of that offset in the same cycle as a remote write returns the newly written value.
- R6: With an expected value of zero, the wait completes with a match on any nonzero status. On completion, `wait_done_o` pulses for one cycle and `wait_busy_o` drops.
- R7: With a nonzero expected value, only an exactly equal status completes the wait. A different nonzero status leaves it waiting.
- R8: A status with bit 31 set ends the wait as an error on the first check, whatever the expected value.
- R9: A wait started with limit L checks the status on the L+1 edges that follow the start. If none of these checks completes the wait, `wait_timeout_o` rises on the last of them. The flag stays high until the next wait start, which clears it.
- R10: `wait_sel_i` = 0 watches the first-stage status and 1 watches the second-stage status. A status that arrives while the wait is running completes it on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_addr_i | input | 5 | Host byte offset |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Read data, valid one cycle after the read strobe |
| stage1_we_i | input | 1 | Remote first-stage status write |
| stage1_data_i | input | DW | First-stage status value |
| stage2_we_i | input | 1 | Remote second-stage status write |
| stage2_data_i | input | DW | Second-stage status value |
| image_addr_o | output | DW | Boot image address |
| meta_addr_o | output | DW | Metadata address |
| code_start_o | output | DW | Code start address |
| code_len_o | output | DW | Accumulated code length |
| meta_ready_o | output | 1 | One-cycle strobe on the metadata-ready command |
| load_ready_o | output | 1 | One-cycle strobe on the load-ready command |
| wait_start_i | input | 1 | Start (or restart) a wait |
| wait_sel_i | input | 1 | Status to watch: 0 first stage, 1 second stage |
| wait_expect_i | input | DW | Expected value, 0 means any nonzero |
| wait_cycles_i | input | CW | Cycle limit for the wait |
| wait_busy_o | output | 1 | Wait in progress |
| wait_done_o | output | 1 | One-cycle completion strobe |
| wait_match_o | output | 1 | Sticky: wait ended on a match |
| wait_err_o | output | 1 | Sticky: wait ended on a negative status |
| wait_timeout_o | output | 1 | Sticky: wait ended on the limit |

## Verification
The waiter is exercised with several status patterns, each of which separates one behaviour from a neighbouring one:
- Small nonzero values under a zero expectation separate any-nonzero mode from exact mode.
- A near-miss value under an exact expectation separates exact comparison from a plain nonzero test.
- Sign-bit values under both modes show that the error check takes precedence.
- A zero status shows the timeout path.
- A run where the two stage registers hold different values shows that the select input, and not the most recently written register, decides which status is watched.
- Directed cases probe the exact cycle on which the timeout rises, a status that arrives partway through a wait, command decode, ignored status writes, and the priority of a remote write over a host read in the same cycle.

// File: rtl/boot_mbox_pkg.sv
package boot_mbox_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_IMAGE  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STAGE1 = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAGE2 = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_META   = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_CSTART = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_CLEN   = 5'h18;

  localparam int CMD_META_READY = 1;
  localparam int CMD_LOAD_READY = 2;

  localparam int NUM_HOST_REGS = 5;
  localparam int IDX_IMAGE  = 0;
  localparam int IDX_CMD    = 1;
  localparam int IDX_META   = 2;
  localparam int IDX_CSTART = 3;
  localparam int IDX_CLEN   = 4;
endpackage

// File: rtl/boot_mbox_regs.sv
module boot_mbox_regs
  import boot_mbox_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  input  logic              stage1_we_i,
  input  logic [DW-1:0]     stage1_data_i,
  input  logic              stage2_we_i,
  input  logic [DW-1:0]     stage2_data_i,
  output logic [DW-1:0]     image_o,
  output logic [DW-1:0]     cmd_o,
  output logic [DW-1:0]     meta_o,
  output logic [DW-1:0]     cstart_o,
  output logic [DW-1:0]     clen_o,
  output logic [DW-1:0]     stage1_o,
  output logic [DW-1:0]     stage2_o,
  output logic              meta_rdy_o,
  output logic              load_rdy_o
);
  localparam logic [ADDR_W-1:0] HOST_OFF [NUM_HOST_REGS] =
    '{OFF_IMAGE, OFF_CMD, OFF_META, OFF_CSTART, OFF_CLEN};

  logic [DW-1:0] host_q [NUM_HOST_REGS];
  logic [DW-1:0] st1_q, st2_q, st1_nx, st2_nx, rd_nx, rdata_q;
  logic          cmd_wr, meta_q, load_q;

  assign st1_nx = stage1_we_i ? stage1_data_i : st1_q;
  assign st2_nx = stage2_we_i ? stage2_data_i : st2_q;
  assign cmd_wr = host_we_i && (host_addr_i == OFF_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_HOST_REGS; i++) host_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_HOST_REGS; i++)
        if (host_we_i && (host_addr_i == HOST_OFF[i])) host_q[i] <= host_wdata_i;
    end
  end

  // status registers are written by the remote side only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= st1_nx;
      st2_q <= st2_nx;
    end
  end

  always_comb begin
    rd_nx = '0;
    for (int i = 0; i < NUM_HOST_REGS; i++)
      if (host_addr_i == HOST_OFF[i]) rd_nx = host_q[i];
    if (host_addr_i == OFF_STAGE1) rd_nx = st1_nx;
    if (host_addr_i == OFF_STAGE2) rd_nx = st2_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      meta_q  <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      if (host_re_i) rdata_q <= rd_nx;
      meta_q <= cmd_wr && (host_wdata_i == DW'(CMD_META_READY));
      load_q <= cmd_wr && (host_wdata_i == DW'(CMD_LOAD_READY));
    end
  end

  assign host_rdata_o = rdata_q;
  assign image_o      = host_q[IDX_IMAGE];
  assign cmd_o        = host_q[IDX_CMD];
  assign meta_o       = host_q[IDX_META];
  assign cstart_o     = host_q[IDX_CSTART];
  assign clen_o       = host_q[IDX_CLEN];
  assign stage1_o     = st1_q;
  assign stage2_o     = st2_q;
  assign meta_rdy_o   = meta_q;
  assign load_rdy_o   = load_q;
endmodule

// File: rtl/boot_mbox_waiter.sv
module boot_mbox_waiter #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sel_i,
  input  logic [DW-1:0] expect_i,
  input  logic [CW-1:0] cycles_i,
  input  logic [DW-1:0] stage1_i,
  input  logic [DW-1:0] stage2_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          match_o,
  output logic          err_o,
  output logic          timeout_o
);
  logic          busy_q, done_q, match_q, err_q, to_q, sel_q;
  logic [DW-1:0] exp_q, stat;
  logic [CW-1:0] lim_q, cnt_q;
  logic          neg, hit, expired;

  assign stat    = sel_q ? stage2_i : stage1_i;
  assign neg     = stat[DW-1];
  assign hit     = (exp_q == '0) ? (stat != '0) : (stat == exp_q);
  assign expired = (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; match_q <= 1'b0;
      err_q  <= 1'b0; to_q   <= 1'b0; sel_q   <= 1'b0;
      exp_q  <= '0;   lim_q  <= '0;   cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        sel_q   <= sel_i;
        exp_q   <= expect_i;
        lim_q   <= cycles_i;
        cnt_q   <= '0;
        match_q <= 1'b0;
        err_q   <= 1'b0;
        to_q    <= 1'b0;
      end else if (busy_q) begin
        // sign bit outranks a match, a match outranks the limit
        if (neg) begin
          err_q <= 1'b1; busy_q <= 1'b0; done_q <= 1'b1;
        end else if (hit) begin
          match_q <= 1'b1; busy_q <= 1'b0; done_q <= 1'b1;
        end else if (expired) begin
          to_q <= 1'b1; busy_q <= 1'b0; done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign match_o   = match_q;
  assign err_o     = err_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/boot_mbox.sv
module boot_mbox
  import boot_mbox_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  input  logic              stage1_we_i,
  input  logic [DW-1:0]     stage1_data_i,
  input  logic              stage2_we_i,
  input  logic [DW-1:0]     stage2_data_i,
  output logic [DW-1:0]     image_addr_o,
  output logic [DW-1:0]     meta_addr_o,
  output logic [DW-1:0]     code_start_o,
  output logic [DW-1:0]     code_len_o,
  output logic              meta_ready_o,
  output logic              load_ready_o,
  input  logic              wait_start_i,
  input  logic              wait_sel_i,
  input  logic [DW-1:0]     wait_expect_i,
  input  logic [CW-1:0]     wait_cycles_i,
  output logic              wait_busy_o,
  output logic              wait_done_o,
  output logic              wait_match_o,
  output logic              wait_err_o,
  output logic              wait_timeout_o
);
  logic [DW-1:0] stage1_q, stage2_q, cmd_q;

  boot_mbox_regs #(.DW(DW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_re_i    (host_re_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .stage1_we_i  (stage1_we_i),
    .stage1_data_i(stage1_data_i),
    .stage2_we_i  (stage2_we_i),
    .stage2_data_i(stage2_data_i),
    .image_o      (image_addr_o),
    .cmd_o        (cmd_q),
    .meta_o       (meta_addr_o),
    .cstart_o     (code_start_o),
    .clen_o       (code_len_o),
    .stage1_o     (stage1_q),
    .stage2_o     (stage2_q),
    .meta_rdy_o   (meta_ready_o),
    .load_rdy_o   (load_ready_o)
  );

  boot_mbox_waiter #(.DW(DW), .CW(CW)) u_waiter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wait_start_i),
    .sel_i    (wait_sel_i),
    .expect_i (wait_expect_i),
    .cycles_i (wait_cycles_i),
    .stage1_i (stage1_q),
    .stage2_i (stage2_q),
    .busy_o   (wait_busy_o),
    .done_o   (wait_done_o),
    .match_o  (wait_match_o),
    .err_o    (wait_err_o),
    .timeout_o(wait_timeout_o)
  );
endmodule

// File: rtl/boot_mbox_chk.sv
module boot_mbox_chk
  import boot_mbox_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_we_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [DW-1:0]     host_wdata_i,
  input logic              stage1_we_i,
  input logic              stage2_we_i,
  input logic [DW-1:0]     stage1_q,
  input logic [DW-1:0]     stage2_q,
  input logic              meta_ready_o,
  input logic              load_ready_o,
  input logic              wait_start_i,
  input logic              wait_busy_o,
  input logic              wait_done_o,
  input logic              wait_match_o,
  input logic              wait_err_o,
  input logic              wait_timeout_o
);
  p_meta_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i && host_addr_i == OFF_CMD && host_wdata_i == DW'(CMD_META_READY)
    |=> meta_ready_o && !load_ready_o);

  p_strobes_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(meta_ready_o && load_ready_o));

  p_stage1_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage1_we_i |=> $stable(stage1_q));

  p_stage2_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage2_we_i |=> $stable(stage2_q));

  p_done_one_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_done_o |-> !wait_busy_o &&
      $countones({wait_match_o, wait_err_o, wait_timeout_o}) == 1);

  p_neg_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_busy_o && !wait_start_i && stage1_q[DW-1] && stage2_q[DW-1]
    |=> wait_err_o && !wait_busy_o);

  p_timeout_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_timeout_o && !wait_start_i |=> wait_timeout_o);

  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_start_i |=> wait_busy_o && !wait_timeout_o && !wait_err_o && !wait_match_o);
endmodule

bind boot_mbox boot_mbox_chk #(.DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_we_i     (host_we_i),
  .host_addr_i   (host_addr_i),
  .host_wdata_i  (host_wdata_i),
  .stage1_we_i   (stage1_we_i),
  .stage2_we_i   (stage2_we_i),
  .stage1_q      (stage1_q),
  .stage2_q      (stage2_q),
  .meta_ready_o  (meta_ready_o),
  .load_ready_o  (load_ready_o),
  .wait_start_i  (wait_start_i),
  .wait_busy_o   (wait_busy_o),
  .wait_done_o   (wait_done_o),
  .wait_match_o  (wait_match_o),
  .wait_err_o    (wait_err_o),
  .wait_timeout_o(wait_timeout_o)
);

// File: tb/boot_mbox_test.sv
module boot_mbox_test;
  localparam int DW  = 32;
  localparam int CW  = 16;
  localparam int LIM = 4;
  localparam int NV  = 11;
  // {post_sel, post_val, wait_sel, expect, result: 1 match, 2 error, 3 timeout}
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 32'h0000_0001, 1'b0, 32'h0, 2'd1},
    {1'b0, 32'h0000_0007, 1'b0, 32'h0, 2'd1},
    {1'b1, 32'h0000_0002, 1'b1, 32'h0, 2'd1},
    {1'b1, 32'h0000_0003, 1'b1, 32'h4, 2'd3},
    {1'b1, 32'h0000_0004, 1'b1, 32'h4, 2'd1},
    {1'b0, 32'h0000_0001, 1'b1, 32'h1, 2'd3},
    {1'b0, 32'h0000_0001, 1'b0, 32'h1, 2'd1},
    {1'b1, 32'h0000_0000, 1'b1, 32'h0, 2'd3},
    {1'b1, 32'h8000_0003, 1'b1, 32'h3, 2'd2},
    {1'b0, 32'h8000_0000, 1'b0, 32'h0, 2'd2},
    {1'b0, 32'hFFFF_FFFF, 1'b0, 32'h5, 2'd2}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic host_we_i = 0, host_re_i = 0;
  logic [4:0] host_addr_i = '0;
  logic [DW-1:0] host_wdata_i = '0, host_rdata_o;
  logic stage1_we_i = 0, stage2_we_i = 0;
  logic [DW-1:0] stage1_data_i = '0, stage2_data_i = '0;
  logic [DW-1:0] image_addr_o, meta_addr_o, code_start_o, code_len_o;
  logic meta_ready_o, load_ready_o;
  logic wait_start_i = 0, wait_sel_i = 0;
  logic [DW-1:0] wait_expect_i = '0;
  logic [CW-1:0] wait_cycles_i = '0;
  logic wait_busy_o, wait_done_o, wait_match_o, wait_err_o, wait_timeout_o;

  int errors = 0, checks = 0;
  logic [DW-1:0] rv;

  always #5 clk_i = ~clk_i;

  boot_mbox #(.DW(DW), .CW(CW)) uut (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_i); endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    host_we_i = 1; host_addr_i = a; host_wdata_i = d; tick(); host_we_i = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
    host_re_i = 1; host_addr_i = a; tick(); host_re_i = 0; d = host_rdata_o;
  endtask

  task automatic post(input logic s, input logic [DW-1:0] v);
    if (s) begin stage2_we_i = 1; stage2_data_i = v; end
    else   begin stage1_we_i = 1; stage1_data_i = v; end
    tick(); stage1_we_i = 0; stage2_we_i = 0;
  endtask

  task automatic start(input logic s, input logic [DW-1:0] e, input int n);
    wait_start_i = 1; wait_sel_i = s; wait_expect_i = e; wait_cycles_i = CW'(n);
    tick(); wait_start_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick(); rst_ni = 1; tick();
    // reset state
    chk("R1 busy", DW'(wait_busy_o), 0);
    chk("R1 flags", DW'({wait_match_o, wait_err_o, wait_timeout_o, meta_ready_o, load_ready_o}), 0);
    rd(5'h00, rv); chk("R1 image", rv, 0);
    rd(5'h0C, rv); chk("R1 stage2", rv, 0);

    // host registers
    wr(5'h00, 32'h1234_5678); wr(5'h10, 32'hA000_0010);
    wr(5'h14, 32'h0800_0000); wr(5'h18, 32'h0);
    wr(5'h18, 32'h0000_3000);
    rd(5'h00, rv); chk("R2 image", rv, 32'h1234_5678);
    rd(5'h10, rv); chk("R2 meta", rv, 32'hA000_0010);
    rd(5'h14, rv); chk("R2 cstart", rv, 32'h0800_0000);
    wr(5'h18, code_len_o + 32'h0000_1200);
    rd(5'h18, rv); chk("R2 clen accumulated", rv, 32'h0000_4200);
    rd(5'h1C, rv); chk("R2 unmapped", rv, 0);
    chk("R2 image port", image_addr_o, 32'h1234_5678);

    // command decode
    wr(5'h08, 32'd1);
    chk("R3 meta strobe", DW'({meta_ready_o, load_ready_o}), 2'b10);
    tick(); chk("R3 meta one cycle", DW'(meta_ready_o), 0);
    wr(5'h08, 32'd2);
    chk("R3 load strobe", DW'({meta_ready_o, load_ready_o}), 2'b01);
    tick(); chk("R3 load one cycle", DW'(load_ready_o), 0);
    wr(5'h08, 32'd3);
    chk("R3 other cmd", DW'({meta_ready_o, load_ready_o}), 0);
    rd(5'h08, rv); chk("R3 cmd readback", rv, 32'd3);

    // status offsets ignore host writes
    post(1'b0, 32'h0000_0001);
    wr(5'h04, 32'hDEAD_BEEF); wr(5'h0C, 32'hCAFE_0000);
    rd(5'h04, rv); chk("R4 stage1 kept", rv, 32'h1);
    rd(5'h0C, rv); chk("R4 stage2 kept", rv, 32'h0);

    // remote write wins over same-cycle read
    stage2_we_i = 1; stage2_data_i = 32'h0000_0002;
    host_re_i = 1; host_addr_i = 5'h0C; tick();
    stage2_we_i = 0; host_re_i = 0;
    chk("R5 same-cycle read", host_rdata_o, 32'h2);

    // waiter vector walk
    for (int i = 0; i < NV; i++) begin
      post(VEC[i][67], VEC[i][66:35]);
      start(VEC[i][34], VEC[i][33:2], LIM);
      repeat (LIM + 3) tick();
      chk($sformatf("R6 R7 R8 R9 R10 vec%0d busy", i), DW'(wait_busy_o), 0);
      chk($sformatf("R6 R7 R8 R9 R10 vec%0d result", i),
          DW'({wait_match_o, wait_err_o, wait_timeout_o}),
          (VEC[i][1:0] == 2'd1) ? 3'b100 : (VEC[i][1:0] == 2'd2) ? 3'b010 : 3'b001);
    end

    // timeout edge: limit 6 -> flag after 7th edge
    post(1'b0, 32'h0);
    start(1'b0, 32'h0, 6);
    repeat (6) tick();
    chk("R9 not yet", DW'({wait_busy_o, wait_timeout_o}), 2'b10);
    tick();
    chk("R9 timeout edge", DW'({wait_busy_o, wait_timeout_o, wait_done_o}), 3'b011);
    repeat (3) tick();
    chk("R9 sticky", DW'(wait_timeout_o), 1);

    // late arrival; the start also clears the sticky flag
    start(1'b0, 32'h2, 20);
    chk("R9 cleared on start", DW'({wait_busy_o, wait_timeout_o}), 2'b10);
    repeat (3) tick();
    post(1'b0, 32'h2);
    chk("R10 still busy", DW'({wait_busy_o, wait_done_o}), 2'b10);
    tick();
    chk("R10 late match", DW'({wait_busy_o, wait_done_o, wait_match_o}), 3'b011);
    tick();
    chk("R6 done pulse", DW'(wait_done_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule